// File: doc/BRIEF.md
# Snoop-Aware Mezzanine Cycle Gate

This block sits between a host local-bus slave decoder and four 16-bit mezzanine module slots (a, b, c, d, numbered 0 to 3). When the decoder marks a cycle for a slot, the gate decides when that read, write or interrupt-acknowledge may be started toward the slot. While the host caches are snooping, the gate holds its response until the memory-inhibit line is released. If another local-bus slave ends the cycle first with an acknowledge or an error acknowledge, the gate abandons the cycle.

Each slot has a programmable recovery time. This is a count of clock cycles that is loaded when an access to the slot completes. A new access to that slot is not launched until the count has run down. Each slot also has a width register that selects the data width reported with each launch. A slot pair (a/b or c/d) can be strapped as one double-size module. Accesses to either half of a double pair then go to the even slot of the pair.

Top module: `mezz_cycle_gate`

## Requirements
- R1: With `snoop_ctl` = 2'b00 (snooping inhibited), `mem_inhibit`, `peer_ack` and `peer_err` have no effect. The start strobe appears two cycles after the cycle in which `cyc_start` is sampled.
- R2: With `snoop_ctl` equal to 2'b01, 2'b10 or 2'b11, no start is issued while `mem_inhibit` is high. The start appears on the clock edge that first samples `mem_inhibit` low.
- R3: While the gate is snooping and `mem_inhibit` is high, a sampled `peer_ack` or `peer_err` raises `abandon` for exactly one cycle on the next edge. No start is issued for that cycle, the gate returns to idle, and the next `cyc_start` is served normally.
- R4: If `mem_inhibit` is sampled low in the same cycle as `peer_ack` or `peer_err`, the cycle proceeds to a start and is not abandoned.
- R5: `slot_start` is one-hot or zero. Bit i means slot i (0=a, 1=b, 2=c, 3=d). `start_kind` carries the `cyc_kind` captured with the cycle (0 read, 1 write, 2 interrupt acknowledge).
- R6: `pair_double[0]` set maps slots 0 and 1 to slot 0, and `pair_double[1]` set maps slots 2 and 3 to slot 2. A pair that is not set keeps its slots separate.
- R7: A `slot_done` pulse loads the finished slot's recovery count. If a new cycle to that slot is strobed on the cycle after `slot_done`, its start comes R+2 cycles after that `slot_done` cycle, for a recovery value R of 2 or more. Other slots are not delayed.
- R8: `start_wide` shows the width register of the mapped slot: 1 means 16-bit, 0 means 8-bit. It resets to 1. A `cfg_we` write sets the width and recovery of `cfg_slot`.
- R9: `cyc_start` is ignored while `busy` is high. `busy` rises after a strobe and falls on the edge after `slot_done` or after an abandon.
- R10: After reset, `slot_start` is zero, `abandon` is low, `busy` is low and all recovery counts are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cyc_start | input | 1 | Address-strobe qualified decode of a slot cycle |
| cyc_slot | input | 2 | Addressed slot, 0..3 |
| cyc_kind | input | 2 | 0 read, 1 write, 2 interrupt acknowledge |
| snoop_ctl | input | 2 | Snoop control; 2'b00 means inhibited |
| mem_inhibit | input | 1 | Memory inhibit, high while asserted |
| peer_ack | input | 1 | Transfer acknowledge from another slave |
| peer_err | input | 1 | Transfer error acknowledge from another slave |
| slot_done | input | 1 | Active slot access has completed |
| pair_double | input | 2 | Bit 0: a/b double; bit 1: c/d double |
| cfg_we | input | 1 | Write enable for per-slot settings |
| cfg_slot | input | 2 | Slot whose settings are written |
| cfg_wide | input | 1 | Width to store, 1 = 16-bit |
| cfg_recov | input | REC_W | Recovery cycles to store |
| slot_start | output | 4 | One-hot launch strobe |
| start_kind | output | 2 | Cycle kind of the current access |
| start_wide | output | 1 | Width setting of the mapped slot |
| abandon | output | 1 | One-cycle pulse when a peer ends the cycle |
| busy | output | 1 | Gate holds a cycle |

## Verification
All outputs are registered. A start is due two edges after the strobe edge when nothing stalls it. During snooping, it is due on the edge that samples memory-inhibit low. An abandon is due on the edge that samples the peer termination. The bench drives inputs just after a falling edge and counts rising edges between the strobe and the observed start. It compares that count with these figures and with R+1 for a recovery stall. Where the expected result is "no start", it samples at every falling edge over several cycles.

// File: rtl/mezz_cycle_gate.sv
module mezz_cycle_gate #(
  parameter int REC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start,
  input  logic [1:0]       cyc_slot,
  input  logic [1:0]       cyc_kind,
  input  logic [1:0]       snoop_ctl,
  input  logic             mem_inhibit,
  input  logic             peer_ack,
  input  logic             peer_err,
  input  logic             slot_done,
  input  logic [1:0]       pair_double,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_slot,
  input  logic             cfg_wide,
  input  logic [REC_W-1:0] cfg_recov,
  output logic [3:0]       slot_start,
  output logic [1:0]       start_kind,
  output logic             start_wide,
  output logic             abandon,
  output logic             busy
);
  localparam int NSLOT = 4;

  typedef enum logic [1:0] {S_IDLE, S_SNOOP, S_RECOV, S_ACTIVE} st_t;
  st_t st;

  logic [1:0]       tgt, kind_q;
  logic [NSLOT-1:0] wide_q;
  logic [REC_W-1:0] recov_q [NSLOT];
  logic [REC_W-1:0] rec_cnt [NSLOT];

  wire [1:0] mapped      = pair_double[cyc_slot[1]] ? {cyc_slot[1], 1'b0} : cyc_slot;
  wire       clear_to_go = (snoop_ctl == 2'b00) || !mem_inhibit;
  wire       peer_term   = peer_ack || peer_err;
  wire       rec_free    = (rec_cnt[tgt] == '0);
  wire       finishing   = (st == S_ACTIVE) && slot_done;

  assign busy       = (st != S_IDLE);
  assign start_kind = kind_q;
  assign start_wide = wide_q[tgt];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q <= '1;
      for (int i = 0; i < NSLOT; i++) recov_q[i] <= '0;
    end else if (cfg_we) begin
      wide_q[cfg_slot]  <= cfg_wide;
      recov_q[cfg_slot] <= cfg_recov;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) rec_cnt[i] <= '0;
    end else begin
      for (int i = 0; i < NSLOT; i++) begin
        if (finishing && tgt == 2'(i))
          rec_cnt[i] <= recov_q[i];
        else if (rec_cnt[i] != '0)
          rec_cnt[i] <= rec_cnt[i] - REC_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      tgt        <= '0;
      kind_q     <= '0;
      slot_start <= '0;
      abandon    <= 1'b0;
    end else begin
      slot_start <= '0;
      abandon    <= 1'b0;
      case (st)
        S_IDLE: if (cyc_start) begin
          tgt    <= mapped;
          kind_q <= cyc_kind;
          st     <= S_SNOOP;
        end
        S_SNOOP: begin
          if (clear_to_go) begin
            if (rec_free) begin
              slot_start <= 4'(1) << tgt;
              st         <= S_ACTIVE;
            end else begin
              st <= S_RECOV;
            end
          end else if (peer_term) begin
            abandon <= 1'b1;
            st      <= S_IDLE;
          end
        end
        S_RECOV: if (rec_free) begin
          slot_start <= 4'(1) << tgt;
          st         <= S_ACTIVE;
        end
        S_ACTIVE: if (slot_done) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mezz_cycle_gate_chk.sv
module mezz_cycle_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] snoop_ctl,
  input logic       mem_inhibit,
  input logic       peer_ack,
  input logic       peer_err,
  input logic [1:0] pair_double,
  input logic [3:0] slot_start,
  input logic       abandon,
  input logic       busy,
  input logic       rec_free
);
  a_r5_onehot_start: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_start));

  a_r3_no_start_on_abandon: assert property (@(posedge clk) disable iff (!rst_n)
    abandon |-> (slot_start == 4'b0000));

  a_r3_abandon_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abandon) |-> $past(peer_ack || peer_err) && $past(mem_inhibit) && $past(snoop_ctl != 2'b00));

  a_r3_idle_after_abandon: assert property (@(posedge clk) disable iff (!rst_n)
    abandon |=> !abandon && !busy);

  a_r6_pair_ab_even: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start[1] |-> !pair_double[0]);

  a_r6_pair_cd_even: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start[3] |-> !pair_double[1]);

  a_r7_recovery_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start != 4'b0000) |-> $past(rec_free));

  a_r9_busy_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start != 4'b0000) |-> busy);
endmodule

bind mezz_cycle_gate mezz_cycle_gate_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .snoop_ctl   (snoop_ctl),
  .mem_inhibit (mem_inhibit),
  .peer_ack    (peer_ack),
  .peer_err    (peer_err),
  .pair_double (pair_double),
  .slot_start  (slot_start),
  .abandon     (abandon),
  .busy        (busy),
  .rec_free    (rec_free)
);

// File: tb/mezz_cycle_gate_tb.sv
module mezz_cycle_gate_tb;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rst_n, cyc_start, mem_inhibit, peer_ack, peer_err, slot_done;
  logic       cfg_we, cfg_wide, start_wide, abandon, busy;
  logic [1:0] cyc_slot, cyc_kind, snoop_ctl, pair_double, cfg_slot, start_kind;
  logic [3:0] cfg_recov, slot_start;

  int n_chk = 0, n_err = 0, cnt = 0;
  always @(posedge clk) cnt <= cnt + 1;

  mezz_cycle_gate u_dut (.*);

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  task automatic strobe(logic [1:0] s, logic [1:0] k);
    cyc_start = 1'b1; cyc_slot = s; cyc_kind = k;
    step();
    cyc_start = 1'b0;
  endtask

  task automatic launch(logic [1:0] s, logic [1:0] k, output int lat, output logic [3:0] seen);
    int t0;
    t0 = cnt;
    strobe(s, k);
    for (int i = 0; i < 30 && slot_start == 4'b0000; i++) step();
    lat = cnt - t0;
    seen = slot_start;
  endtask

  task automatic finish_access();
    slot_done = 1'b1; step(); slot_done = 1'b0;
  endtask

  task automatic set_cfg(logic [1:0] s, logic w, logic [3:0] r);
    cfg_we = 1'b1; cfg_slot = s; cfg_wide = w; cfg_recov = r;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 start after reset", slot_start, 0);
    chk("R10 abandon after reset", abandon, 0);
    chk("R10 busy after reset", busy, 0);
  endtask

  task automatic t_inhibited();
    int lat; logic [3:0] s;
    snoop_ctl = 2'b00; mem_inhibit = 1'b1; peer_ack = 1'b1;
    launch(2'd0, 2'd1, lat, s);
    chk("R1 latency with snoop inhibited", lat, 2);
    chk("R1 start slot a", s, 4'b0001);
    chk("R5 kind write", start_kind, 1);
    chk("R1 no abandon", abandon, 0);
    peer_ack = 1'b0;
    finish_access();
    launch(2'd2, 2'd2, lat, s);
    chk("R5 start slot c", s, 4'b0100);
    chk("R5 kind iack", start_kind, 2);
    finish_access();
    mem_inhibit = 1'b0;
  endtask

  task automatic t_snoop_wait();
    for (int m = 1; m < 4; m++) begin
      snoop_ctl = 2'(m); mem_inhibit = 1'b1;
      strobe(2'd2, 2'd0);
      for (int i = 0; i < 4; i++) begin
        chk("R2 held while inhibit asserted", slot_start, 0);
        step();
      end
      mem_inhibit = 1'b0;
      step();
      chk("R2 start on inhibit release", slot_start, 4'b0100);
      finish_access();
    end
  endtask

  task automatic t_abandon();
    int lat; logic [3:0] s;
    snoop_ctl = 2'b10; mem_inhibit = 1'b1;
    strobe(2'd1, 2'd0);
    step(2);
    peer_err = 1'b1;
    step();
    peer_err = 1'b0;
    chk("R3 abandon pulse", abandon, 1);
    chk("R3 no start on abandon", slot_start, 0);
    step();
    chk("R3 abandon one cycle", abandon, 0);
    chk("R3 idle after abandon", busy, 0);
    mem_inhibit = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R3 no late start", slot_start, 0);
    end
    snoop_ctl = 2'b01;
    launch(2'd1, 2'd0, lat, s);
    chk("R3 next strobe served", lat, 2);
    chk("R3 next strobe slot b", s, 4'b0010);
    finish_access();
  endtask

  task automatic t_tie();
    snoop_ctl = 2'b01; mem_inhibit = 1'b1;
    strobe(2'd0, 2'd0);
    step();
    mem_inhibit = 1'b0; peer_ack = 1'b1;
    step();
    peer_ack = 1'b0;
    chk("R4 release wins tie", slot_start, 4'b0001);
    chk("R4 no abandon on tie", abandon, 0);
    finish_access();
  endtask

  task automatic t_pairs();
    int lat; logic [3:0] s;
    snoop_ctl = 2'b00;
    set_cfg(2'd0, 1'b0, 4'd0);
    set_cfg(2'd1, 1'b1, 4'd0);
    pair_double = 2'b01;
    launch(2'd1, 2'd0, lat, s);
    chk("R6 b maps to a when a/b double", s, 4'b0001);
    chk("R8 width from combined slot", start_wide, 0);
    finish_access();
    pair_double = 2'b10;
    launch(2'd3, 2'd0, lat, s);
    chk("R6 d maps to c when c/d double", s, 4'b0100);
    finish_access();
    launch(2'd1, 2'd0, lat, s);
    chk("R6 b separate when a/b single", s, 4'b0010);
    chk("R8 width of slot b", start_wide, 1);
    finish_access();
    pair_double = 2'b00;
    launch(2'd3, 2'd0, lat, s);
    chk("R6 d separate when c/d single", s, 4'b1000);
    finish_access();
  endtask

  task automatic t_width();
    int lat; logic [3:0] s;
    set_cfg(2'd3, 1'b0, 4'd0);
    launch(2'd3, 2'd0, lat, s);
    chk("R8 narrow slot d", start_wide, 0);
    finish_access();
    set_cfg(2'd3, 1'b1, 4'd0);
    launch(2'd3, 2'd0, lat, s);
    chk("R8 wide slot d", start_wide, 1);
    finish_access();
  endtask

  task automatic t_recovery();
    int lat; logic [3:0] s;
    set_cfg(2'd2, 1'b1, 4'd5);
    launch(2'd2, 2'd0, lat, s);
    chk("R7 first access not delayed", lat, 2);
    finish_access();
    launch(2'd2, 2'd0, lat, s);
    chk("R7 back-to-back stalled R+1 after strobe", lat, 6);
    chk("R7 stalled start slot c", s, 4'b0100);
    finish_access();
    launch(2'd0, 2'd0, lat, s);
    chk("R7 other slot not delayed", lat, 2);
    finish_access();
    set_cfg(2'd2, 1'b1, 4'd0);
  endtask

  task automatic t_busy();
    int lat; logic [3:0] s;
    launch(2'd0, 2'd0, lat, s);
    strobe(2'd1, 2'd1);
    for (int i = 0; i < 3; i++) begin
      chk("R9 strobe ignored while busy", slot_start, 0);
      step();
    end
    chk("R9 busy while active", busy, 1);
    finish_access();
    chk("R9 busy falls after done", busy, 0);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R9 ignored strobe never launches", slot_start, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cnt, 0);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cyc_start = 1'b0; cyc_slot = '0; cyc_kind = '0;
    snoop_ctl = 2'b00; mem_inhibit = 1'b0; peer_ack = 1'b0; peer_err = 1'b0;
    slot_done = 1'b0; pair_double = 2'b00;
    cfg_we = 1'b0; cfg_slot = '0; cfg_wide = 1'b1; cfg_recov = '0;
    step(3);
    rst_n = 1'b1;
    step();
    t_reset();
    t_inhibited();
    t_snoop_wait();
    t_abandon();
    t_tie();
    t_pairs();
    t_width();
    t_recovery();
    t_busy();
    summary();
    $finish;
  end
endmodule